// File: doc/BRIEF.md
# Phase-Aligned Serial Game-Pad Port

This block sits between a CPU bus and two serial game pads. The CPU bus cycles alternate between a "get" phase and a "put" phase. A small toggle inside the block tracks the phase: it starts on get after reset and flips every clock. The block also exposes this toggle.

A CPU write to the strobe address does not reach the pads at once. The strobe level is held pending and is released only at the end of a get cycle, which is the get-to-put boundary. A CPU read of a data port returns the pad's current serial bit and asks that pad to shift. The pad shifts one cycle later. If the previous cycle read the same port, the read instead returns the value captured earlier and does not shift the pad.

The block also owns the frame interrupt flag. A read of the status address requests a clear. The clear takes effect only at the end of a put cycle. Because of this, two consecutive status reads that start on a get cycle both see the flag still set.

Top module: `padport_top`

## Requirements
- R1: After reset, `pad_latch`, `pad_clk` and `frame_irq` are 0, and `cyc_put` is 0 (get phase).
- R2: `cyc_put` is 0 in cycle 0 after reset and inverts every clock, so cycle k is a put cycle exactly when k is odd.
- R3: A write to address 0x4016 takes its bit 0 as the strobe level. In a get cycle, the write drives `pad_latch` from the next cycle on. In a put cycle, the level is held pending and drives `pad_latch` only after the following get cycle ends. `pad_latch` never changes at the end of a put cycle, and a write to 0x4017 never changes it.
- R4: A port read decodes 0x4016 as port 0 and 0x4017 as port 1. If the previous cycle did not read the same port, the read returns `pad_bit[p]` in `rd_data[0]`. In the next cycle `pad_clk[p]` is high for one cycle, and the other port's clock stays low.
- R5: If the previous cycle read the same port, the read returns the same bit as that earlier read. `pad_clk[p]` then stays low in the cycle after it, so the pad shifts only once for the pair.
- R6: Alternating reads of port 0 and port 1 in consecutive cycles each count as fresh reads and each clock their own pad. `pad_clk` never has more than one bit high.
- R7: A port read returns bits 7:5 equal to bits 7:5 of the most recent CPU write to any address, or 0 if no write has occurred since reset. Bits 4:1 are 0.
- R8: A status read (address 0x4015) returns the interrupt flag in bit 6 and 0 in every other bit. `frame_irq` outputs the flag.
- R9: A status read requests a clear. The clear is applied at the end of the first put cycle that starts at or after the read. A status read in a get cycle followed by one in the put cycle returns the flag set both times. A read after the clear returns 0.
- R10: `frame_irq_set` sets the flag at the end of its cycle and wins over a clear at the same edge. A pending clear is used up at that edge.
- R11: When `cpu_rd` is low, or the address decodes to nothing, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, one bus cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_rd | input | 1 | CPU read strobe for this cycle |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_wdata | input | 8 | CPU write data |
| frame_irq_set | input | 1 | Pulse that raises the frame interrupt flag |
| pad_bit | input | 2 | Serial data bit from each pad, index = port |
| rd_data | output | 8 | Read data for the addressed register |
| pad_latch | output | 1 | Strobe level delivered to both pads |
| pad_clk | output | 2 | One-cycle shift pulse per pad |
| frame_irq | output | 1 | Frame interrupt flag |
| cyc_put | output | 1 | 1 during a put cycle, 0 during a get cycle |

## Verification
The embedded properties check several rules on every cycle:
- a strobe level moves only at the end of a get cycle, and a put-cycle write never moves it at once;
- the flag falls only after a put cycle, and a set always leaves it high;
- a repeated read of the same port neither clocks the pad nor changes the returned bit;
- at most one pad clock is high at a time.

Only the bench scenarios can show the data content. These are:
- the serial bits of many latched patterns arriving in order on both ports;
- the upper bits following the last written byte;
- the exact cycle in which a pending strobe or a pending clear becomes visible;
- the double status read that still sees the flag.

// File: rtl/padport_pkg.sv
package padport_pkg;

    // Address width of the CPU bus.
    localparam int ADDR_W  = 16;
    // Low bits of a port read that come from the pad path.
    localparam int PATH_W  = 5;
    // Bit of the status byte that carries the interrupt flag.
    localparam int IRQ_BIT = 6;
    // Width of the decoded port index.
    localparam int PIDX_W  = 4;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_STAT = 2'd1,
        ACC_PORT = 2'd2,
        ACC_STRB = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e              kind;
        logic [PIDX_W-1:0] idx;
    } acc_t;

    // Classify one bus cycle into the access the block must serve.
    function automatic acc_t decode_acc(
        input logic [ADDR_W-1:0] addr,
        input logic              rd,
        input logic              wr,
        input logic [ADDR_W-1:0] port_base,
        input logic [ADDR_W-1:0] stat_addr,
        input int                nports
    );
        acc_t r;
        r.kind = ACC_IDLE;
        r.idx  = '0;
        if (wr && addr == port_base) begin
            r.kind = ACC_STRB;
        end else if (rd && addr == stat_addr) begin
            r.kind = ACC_STAT;
        end else if (rd) begin
            for (int i = 0; i < nports; i++) begin
                if (addr == port_base + ADDR_W'(i)) begin
                    r.kind = ACC_PORT;
                    r.idx  = PIDX_W'(i);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/padport_phase.sv
module padport_phase (
    input  logic clk,
    input  logic rst,
    output logic put_q
);
    // Free-running get/put parity, get first after reset.
    always_ff @(posedge clk) begin
        if (rst) put_q <= 1'b0;
        else     put_q <= ~put_q;
    end
endmodule

// File: rtl/padport_strobe.sv
module padport_strobe (
    input  logic clk,
    input  logic rst,
    input  logic in_get,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic latch_q
);
    logic pend_q;
    logic val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            val_q   <= 1'b0;
            latch_q <= 1'b0;
        end else if (in_get) begin
            // get -> put boundary: release the newest strobe level
            if (wr_hit)      latch_q <= wr_bit;
            else if (pend_q) latch_q <= val_q;
            pend_q <= 1'b0;
        end else if (wr_hit) begin
            pend_q <= 1'b1;
            val_q  <= wr_bit;
        end
    end

    // R3
    strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(latch_q) |-> $past(in_get));

    // R3
    strobe_defer_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !in_get) |=> $stable(latch_q));
endmodule

// File: rtl/padport_reader.sv
module padport_reader (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic pad_bit,
    output logic bit_o,
    output logic clk_o
);
    logic prev_q;
    logic held_q;

    // A repeat read returns the captured bit instead of the live pad bit.
    assign bit_o = prev_q ? held_q : pad_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
            clk_o  <= 1'b0;
        end else begin
            prev_q <= hit;
            clk_o  <= hit && !prev_q;
            if (hit && !prev_q) held_q <= pad_bit;
        end
    end

    // R4
    clk_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        clk_o |-> $past(hit));

    // R5
    repeat_noclk_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && $past(hit)) |=> !clk_o);

    // R5
    repeat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && $past(hit)) |-> (bit_o == $past(bit_o)));
endmodule

// File: rtl/padport_irq.sv
module padport_irq (
    input  logic clk,
    input  logic rst,
    input  logic in_put,
    input  logic set_i,
    input  logic stat_rd,
    output logic flag_q
);
    logic clr_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q     <= 1'b0;
            clr_pend_q <= 1'b0;
        end else begin
            if (set_i)                             flag_q <= 1'b1;
            else if (in_put && (clr_pend_q || stat_rd)) flag_q <= 1'b0;
            if (in_put)       clr_pend_q <= 1'b0;
            else if (stat_rd) clr_pend_q <= 1'b1;
        end
    end

    // R9
    irq_clear_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(in_put));

    // R10
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);
endmodule

// File: rtl/padport_top.sv
module padport_top #(
    parameter int          NUM_PORTS = 2,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] PORT_BASE = 16'h4016,
    parameter logic [15:0] STAT_ADDR = 16'h4015
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          cpu_addr,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic                 frame_irq_set,
    input  logic [NUM_PORTS-1:0] pad_bit,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 pad_latch,
    output logic [NUM_PORTS-1:0] pad_clk,
    output logic                 frame_irq,
    output logic                 cyc_put
);
    import padport_pkg::*;

    localparam int OPEN_W = DATA_W - PATH_W;

    acc_t                 acc;
    logic [NUM_PORTS-1:0] hit_v;
    logic [NUM_PORTS-1:0] bit_v;
    logic [OPEN_W-1:0]    open_q;
    logic                 sel_bit;
    logic                 unused_wbits;

    assign acc          = decode_acc(cpu_addr, cpu_rd, cpu_wr, PORT_BASE, STAT_ADDR, NUM_PORTS);
    assign unused_wbits = ^cpu_wdata[PATH_W-1:1];

    padport_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .put_q (cyc_put)
    );

    padport_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .in_get  (!cyc_put),
        .wr_hit  (acc.kind == ACC_STRB),
        .wr_bit  (cpu_wdata[0]),
        .latch_q (pad_latch)
    );

    padport_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .in_put  (cyc_put),
        .set_i   (frame_irq_set),
        .stat_rd (acc.kind == ACC_STAT),
        .flag_q  (frame_irq)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign hit_v[g] = (acc.kind == ACC_PORT) && (acc.idx == PIDX_W'(g));
        padport_reader u_rd (
            .clk     (clk),
            .rst     (rst),
            .hit     (hit_v[g]),
            .pad_bit (pad_bit[g]),
            .bit_o   (bit_v[g]),
            .clk_o   (pad_clk[g])
        );
    end

    // Upper bits of a port read echo the last byte the CPU drove.
    always_ff @(posedge clk) begin
        if (rst)         open_q <= '0;
        else if (cpu_wr) open_q <= cpu_wdata[DATA_W-1:PATH_W];
    end

    always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (hit_v[i]) sel_bit = bit_v[i];
        end
    end

    always_comb begin
        rd_data = '0;
        case (acc.kind)
            ACC_STAT: rd_data[IRQ_BIT] = frame_irq;
            ACC_PORT: rd_data = {open_q, {(PATH_W-1){1'b0}}, sel_bit};
            default:  rd_data = '0;
        endcase
    end

    // R6
    pad_clk_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pad_clk));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |-> (rd_data == '0));
endmodule

// File: tb/padport_tb.sv
module padport_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        frame_irq_set = 1'b0;
    logic [1:0]  pad_bit;
    logic [7:0]  rd_data;
    logic        pad_latch;
    logic [1:0]  pad_clk;
    logic        frame_irq;
    logic        cyc_put;

    int n_tests = 0;
    int n_fail  = 0;
    int ncyc    = 0;

    logic [7:0] pat0 = 8'h00, pat1 = 8'h00;
    logic [7:0] sr0 = 8'hFF, sr1 = 8'hFF;

    always #10 clk = ~clk;

    padport_top dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .frame_irq_set(frame_irq_set), .pad_bit(pad_bit),
        .rd_data(rd_data), .pad_latch(pad_latch), .pad_clk(pad_clk),
        .frame_irq(frame_irq), .cyc_put(cyc_put)
    );

    // Pad models: reload while latched, shift in ones on each clock pulse.
    always @(posedge clk) begin
        if (pad_latch) begin
            sr0 <= pat0;
            sr1 <= pat1;
        end else begin
            if (pad_clk[0]) sr0 <= {1'b1, sr0[7:1]};
            if (pad_clk[1]) sr1 <= {1'b1, sr1[7:1]};
        end
    end
    assign pad_bit = {sr1[0], sr0[0]};

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one bus cycle and sample rd_data inside it.
    task automatic bus(input logic rd, input logic wr, input logic [15:0] a,
                       input logic [7:0] d, input logic set, output logic [7:0] r);
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; frame_irq_set = set;
        #5;
        r = rd_data;
    endtask

    task automatic idle();
        logic [7:0] r;
        bus(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, r);
    endtask

    // Make the next driven cycle have parity want (0 get, 1 put).
    task automatic align(input int want);
        while (((ncyc + 1) % 2) != want) idle();
    endtask

    task automatic load_pads(input logic [7:0] p0, input logic [7:0] p1, input logic [7:0] lowbyte);
        logic [7:0] r;
        pat0 = p0; pat1 = p1;
        align(0);
        bus(1'b0, 1'b1, 16'h4016, 8'h01, 1'b0, r);
        idle();
        align(0);
        bus(1'b0, 1'b1, 16'h4016, lowbyte, 1'b0, r);
        idle();
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r, r2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        // R1 reset state
        check("R1 latch", pad_latch, 0);
        check("R1 clk", pad_clk, 0);
        check("R1 irq", frame_irq, 0);
        check("R1 phase", cyc_put, 0);

        // R2 parity
        for (int i = 0; i < 6; i++) begin
            idle();
            check("R2 phase", cyc_put, ncyc % 2);
        end

        // R11 idle read data
        idle();
        check("R11 idle rd_data", rd_data, 0);

        // R3 write in get cycle applies after one edge
        align(0);
        bus(1'b0, 1'b1, 16'h4016, 8'h01, 1'b0, r);
        idle();
        check("R3 get write", pad_latch, 1);
        // R3 write in put cycle waits for the get cycle to end
        align(1);
        bus(1'b0, 1'b1, 16'h4016, 8'h00, 1'b0, r);
        idle();
        check("R3 put write pending", pad_latch, 1);
        idle();
        check("R3 put write applied", pad_latch, 0);
        // R3 write to second port address does not strobe
        align(0);
        bus(1'b0, 1'b1, 16'h4017, 8'h01, 1'b0, r);
        idle();
        idle();
        check("R3 4017 write ignored", pad_latch, 0);

        // R4 / R7 sweep of patterns over both ports
        for (int k = 0; k < 16; k++) begin
            logic [7:0] p0, p1, hi;
            p0 = 8'(k * 29) ^ 8'h5A;
            p1 = {p0[3:0], p0[7:4]} ^ 8'hC3;
            hi = {3'(k), 5'b00000};
            load_pads(p0, p1, hi);
            for (int b = 0; b < 9; b++) begin
                bus(1'b1, 1'b0, 16'h4016, 8'h00, 1'b0, r);
                check("R4 R7 port0 data", r, {hi[7:5], 4'b0000, (b < 8) ? p0[b] : 1'b1});
                idle();
                check("R4 port0 clk", pad_clk, 2'b01);
            end
            for (int b = 0; b < 9; b++) begin
                bus(1'b1, 1'b0, 16'h4017, 8'h00, 1'b0, r);
                check("R4 R7 port1 data", r, {hi[7:5], 4'b0000, (b < 8) ? p1[b] : 1'b1});
                idle();
                check("R4 port1 clk", pad_clk, 2'b10);
            end
        end

        // R5 back-to-back reads of one port
        load_pads(8'b1011_0010, 8'h00, 8'h00);
        bus(1'b1, 1'b0, 16'h4016, 8'h00, 1'b0, r);
        check("R5 first read", r, 8'h00);
        bus(1'b1, 1'b0, 16'h4016, 8'h00, 1'b0, r2);
        check("R5 repeat read holds", r2, 8'h00);
        bus(1'b1, 1'b0, 16'h4016, 8'h00, 1'b0, r2);
        check("R5 third read holds", r2, 8'h00);
        check("R5 no clk on repeat", pad_clk, 2'b00);
        idle();
        check("R5 no clk after repeat", pad_clk, 2'b00);
        bus(1'b1, 1'b0, 16'h4016, 8'h00, 1'b0, r);
        check("R5 single shift", r, 8'h01);

        // R6 alternating reads clock both pads
        load_pads(8'b1100_1010, 8'b0110_0101, 8'h00);
        for (int j = 0; j < 6; j++) begin
            logic [7:0] pp;
            pp = (j % 2 == 0) ? 8'b1100_1010 : 8'b0110_0101;
            bus(1'b1, 1'b0, (j % 2 == 0) ? 16'h4016 : 16'h4017, 8'h00, 1'b0, r);
            check("R6 alternating data", r, {7'b0, pp[j / 2]});
            if (j > 0) check("R6 alternating clk", pad_clk, (j % 2 == 1) ? 2'b01 : 2'b10);
        end

        // R8 / R9 double status read from a get cycle
        bus(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, r);
        idle();
        check("R8 irq output", frame_irq, 1);
        align(0);
        bus(1'b1, 1'b0, 16'h4015, 8'h00, 1'b0, r);
        check("R8 status read", r, 8'h40);
        bus(1'b1, 1'b0, 16'h4015, 8'h00, 1'b0, r);
        check("R9 second read still set", r, 8'h40);
        bus(1'b1, 1'b0, 16'h4015, 8'h00, 1'b0, r);
        check("R9 cleared after put", r, 8'h00);
        check("R9 irq output low", frame_irq, 0);

        // R9 status read in a put cycle clears at once
        bus(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, r);
        align(1);
        bus(1'b1, 1'b0, 16'h4015, 8'h00, 1'b0, r);
        check("R9 put read", r, 8'h40);
        bus(1'b1, 1'b0, 16'h4015, 8'h00, 1'b0, r);
        check("R9 put read cleared", r, 8'h00);

        // R10 set wins over clear at the same edge
        align(1);
        bus(1'b1, 1'b0, 16'h4015, 8'h00, 1'b1, r);
        idle();
        check("R10 set wins", frame_irq, 1);
        idle();
        check("R10 pending clear used up", frame_irq, 1);

        idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule